// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each cycle it takes fire and clear requests from every timer together with that timer's delivery settings, and turns them into interrupt line levels, one-clock edge pulses, or message writes of a 32-bit data word to a 32-bit address. It keeps one pending status bit per timer for level-type delivery.

A global block enable gates all delivery. A legacy routing switch pins timer 0 to line 0 and timer 1 to line 8, whatever their route fields say. The same switch also takes line 8 away from an external real-time-clock interrupt, which otherwise passes through to that line. Message writes from several timers are queued. They leave one per cycle, lowest timer index first.

Top module: `tmr_irq_router`

## Requirements
- R1: After synchronous reset all interrupt lines are low, every status bit is 0 and `msg_valid` is 0.
- R2: A fire on an active timer (block and timer enabled) with `level_trig`=1 and `msg_en`=0 sets that timer's status bit on the next clock. It holds the routed line high until the bit is cleared.
- R3: A fire with `level_trig`=0 and `msg_en`=0 raises the routed line for exactly one clock and leaves the status bit at 0.
- R4: A clear request, a deasserted timer enable or a deasserted block enable clears the status bit and drops the line on the next clock. A clear wins over a fire in the same cycle.
- R5: With `legacy_en`=1, timer 0 drives line 0 and timer 1 drives line 8. Timers 2 and up keep using their `route_sel` field.
- R6: A fire on an active timer with `msg_en`=1 produces, two clocks after the request, one cycle of `msg_valid` with `msg_addr` = route word bits [63:32] and `msg_data` = bits [31:0]. No line is driven and the status bit is unchanged.
- R7: Message fires from several timers in the same cycle leave on consecutive cycles in ascending timer index.
- R8: A rising edge of a timer's `msg_en` clears its status bit and drops any line that timer holds.
- R9: With `legacy_en`=0, line 8 follows `rtc_irq_in` one clock later. With `legacy_en`=1 the input does not reach line 8. Leaving legacy mode shows the current input level on line 8 again.
- R10: Each timer's capability vector in `route_cap` has bit 2 set, advertising line 2 as routable.
- R11: Level holds from several timers that route to the same line are ORed. The line stays high until the last holder is cleared.
- R12: A fire on a timer whose own enable, or the block enable, is 0 changes neither the status bits nor the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_en | input | 1 | Global delivery enable |
| legacy_en | input | 1 | Fixed routing for timers 0 and 1, RTC gated |
| rtc_irq_in | input | 1 | External real-time-clock interrupt level |
| fire_req | input | NUM_TMR | Per-timer fire request |
| clr_req | input | NUM_TMR | Per-timer clear request |
| tmr_en | input | NUM_TMR | Per-timer enable |
| level_trig | input | NUM_TMR | 1 = level delivery, 0 = edge pulse |
| msg_en | input | NUM_TMR | 1 = message delivery instead of a line |
| route_sel | input | NUM_TMR*ROUTE_W | Per-timer line index, timer i at bits [i*ROUTE_W +: ROUTE_W] |
| msg_route | input | NUM_TMR*64 | Per-timer message word: [63:32] address, [31:0] data |
| irq_lines | output | NUM_LINES | Interrupt line levels |
| status | output | NUM_TMR | Pending level status per timer |
| msg_valid | output | 1 | Message write strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| route_cap | output | NUM_TMR*NUM_LINES | Per-timer routable-line capability vector |

## Verification
A fire and a clear can reach the same timer in the same clock. The bench drives both requests for a level-type timer in one cycle and expects the status bit and the line to stay low on the next sample. Message fires from two timers can also coincide. The bench raises both in one cycle and expects two back-to-back writes in index order, with the correct address and data on each.

// File: rtl/tir_pkg.sv
// Shared constants and types for the timer interrupt router.
// Assumes at least two timers and more than nine interrupt lines.
package tir_pkg;
    localparam int LEG_T0_LINE = 0;    // fixed line for timer 0 in legacy mode
    localparam int LEG_T1_LINE = 8;    // fixed line for timer 1 and the RTC input
    localparam int CAP_LINE    = 2;    // line advertised in every capability vector
    localparam int MSG_W       = 32;

    typedef struct packed {
        logic [MSG_W-1:0] addr;
        logic [MSG_W-1:0] data;
    } msg_word_t;
endpackage

// File: rtl/tir_slot.sv
// Per-timer delivery state: level hold (which is also the status bit),
// one-clock edge pulse, and pending message flag.
// Assumes requests are synchronous to clk; gnt comes from the message arbiter.
module tir_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_en,
    input  logic tmr_en,
    input  logic fire,
    input  logic clr,
    input  logic level_trig,
    input  logic msg_en,
    input  logic gnt,
    output logic hold,
    output logic pulse,
    output logic pend
);
    logic msg_en_q;
    logic active;
    logic kill;
    logic hold_n;
    logic pulse_n;
    logic pend_n;

    // Work out the next delivery state from requests and enables
    always_comb begin
        active  = blk_en & tmr_en;
        kill    = clr | ~active | (msg_en & ~msg_en_q);
        hold_n  = hold;
        if (kill)
            hold_n = 1'b0;
        else if (fire && !msg_en)
            hold_n = level_trig;
        pulse_n = ~kill & fire & ~msg_en & ~level_trig;
        pend_n  = (pend & ~gnt) | (active & fire & msg_en);
    end

    // Register the delivery state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_en_q <= 1'b0;
            hold     <= 1'b0;
            pulse    <= 1'b0;
            pend     <= 1'b0;
        end else begin
            msg_en_q <= msg_en;
            hold     <= hold_n;
            pulse    <= pulse_n;
            pend     <= pend_n;
        end
    end
endmodule

// File: rtl/tir_line_merge.sv
// Maps each timer's hold and pulse onto its selected line and ORs the
// sources together; applies legacy overrides and the RTC pass-through.
// Assumes NUM_LINES > LEG_T1_LINE.
module tir_line_merge
    import tir_pkg::*;
#(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LINES = 32,
    parameter int ROUTE_W   = 5
) (
    input  logic                       legacy_en,
    input  logic                       rtc_lvl,
    input  logic [NUM_TMR-1:0]         hold,
    input  logic [NUM_TMR-1:0]         pulse,
    input  logic [NUM_TMR*ROUTE_W-1:0] route_sel,
    output logic [NUM_LINES-1:0]       lines
);
    // Combine every source onto its target line
    always_comb begin
        lines = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            logic [ROUTE_W-1:0] tgt;
            tgt = route_sel[i*ROUTE_W +: ROUTE_W];
            if (legacy_en && i == 0) tgt = ROUTE_W'(LEG_T0_LINE);
            if (legacy_en && i == 1) tgt = ROUTE_W'(LEG_T1_LINE);
            lines[tgt] = lines[tgt] | hold[i] | pulse[i];
        end
        if (!legacy_en)
            lines[LEG_T1_LINE] = lines[LEG_T1_LINE] | rtc_lvl;
    end
endmodule

// File: rtl/tir_msg_arb.sv
// Grants the lowest-index pending message and registers one write per cycle.
// Assumes msg_route holds the address in the upper half of each 64-bit word.
module tir_msg_arb
    import tir_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_TMR-1:0]     pend,
    input  logic [NUM_TMR*64-1:0]  msg_route,
    output logic [NUM_TMR-1:0]     gnt,
    output logic                   msg_valid,
    output logic [MSG_W-1:0]       msg_addr,
    output logic [MSG_W-1:0]       msg_data
);
    msg_word_t sel;

    // Pick the lowest pending timer and its message word
    always_comb begin
        gnt = '0;
        sel = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (pend[i] && gnt == '0) begin
                gnt[i] = 1'b1;
                sel    = msg_route[i*64 +: 64];
            end
        end
    end

    // Register the granted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else begin
            msg_valid <= |pend;
            msg_addr  <= sel.addr;
            msg_data  <= sel.data;
        end
    end
endmodule

// File: rtl/tmr_irq_router.sv
// Top of the timer interrupt router: per-timer slots, line merge,
// message arbiter and the registered RTC input.
// Assumes NUM_TMR >= 2 and NUM_LINES > 9.
module tmr_irq_router
    import tir_pkg::*;
#(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LINES = 32,
    localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         blk_en,
    input  logic                         legacy_en,
    input  logic                         rtc_irq_in,
    input  logic [NUM_TMR-1:0]           fire_req,
    input  logic [NUM_TMR-1:0]           clr_req,
    input  logic [NUM_TMR-1:0]           tmr_en,
    input  logic [NUM_TMR-1:0]           level_trig,
    input  logic [NUM_TMR-1:0]           msg_en,
    input  logic [NUM_TMR*ROUTE_W-1:0]   route_sel,
    input  logic [NUM_TMR*64-1:0]        msg_route,
    output logic [NUM_LINES-1:0]         irq_lines,
    output logic [NUM_TMR-1:0]           status,
    output logic                         msg_valid,
    output logic [MSG_W-1:0]             msg_addr,
    output logic [MSG_W-1:0]             msg_data,
    output logic [NUM_TMR*NUM_LINES-1:0] route_cap
);
    logic [NUM_TMR-1:0] hold;
    logic [NUM_TMR-1:0] pulse;
    logic [NUM_TMR-1:0] pend;
    logic [NUM_TMR-1:0] msg_gnt;
    logic               rtc_q;

    // Sample the external RTC level
    always_ff @(posedge clk) begin
        if (!rst_n) rtc_q <= 1'b0;
        else        rtc_q <= rtc_irq_in;
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_slot
        tir_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .blk_en     (blk_en),
            .tmr_en     (tmr_en[i]),
            .fire       (fire_req[i]),
            .clr        (clr_req[i]),
            .level_trig (level_trig[i]),
            .msg_en     (msg_en[i]),
            .gnt        (msg_gnt[i]),
            .hold       (hold[i]),
            .pulse      (pulse[i]),
            .pend       (pend[i])
        );
        assign route_cap[i*NUM_LINES +: NUM_LINES] = NUM_LINES'(1) << CAP_LINE;
    end

    assign status = hold;

    tir_line_merge #(
        .NUM_TMR   (NUM_TMR),
        .NUM_LINES (NUM_LINES),
        .ROUTE_W   (ROUTE_W)
    ) u_merge (
        .legacy_en (legacy_en),
        .rtc_lvl   (rtc_q),
        .hold      (hold),
        .pulse     (pulse),
        .route_sel (route_sel),
        .lines     (irq_lines)
    );

    tir_msg_arb #(
        .NUM_TMR (NUM_TMR)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .msg_route (msg_route),
        .gnt       (msg_gnt),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );
endmodule

// File: rtl/tir_chk.sv
// Property checker for the timer interrupt router, bound to the top.
// Assumes the default legacy line numbers from tir_pkg.
module tir_chk
    import tir_pkg::*;
#(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 blk_en,
    input logic                 legacy_en,
    input logic [NUM_TMR-1:0]   fire_req,
    input logic [NUM_TMR-1:0]   clr_req,
    input logic [NUM_TMR-1:0]   tmr_en,
    input logic [NUM_TMR-1:0]   level_trig,
    input logic [NUM_TMR-1:0]   msg_en,
    input logic [NUM_TMR-1:0]   status,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [NUM_TMR-1:0]   gnt
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            fire_req[i] && level_trig[i] && tmr_en[i] && blk_en && !msg_en[i] && !clr_req[i]
            |=> status[i]);                                                      // R2
        AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            fire_req[i] && !level_trig[i] && !msg_en[i] |=> !status[i]);         // R3
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[i] |=> !status[i]);                                          // R4
    end

    AST_BLOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> status == '0);                                               // R4
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));                                                          // R7
    AST_LEGACY_T0: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_en && status[0] |-> irq_lines[LEG_T0_LINE]);                      // R5
    AST_LEGACY_T1: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_en && status[1] |-> irq_lines[LEG_T1_LINE]);                      // R5
endmodule

bind tmr_irq_router tir_chk #(
    .NUM_TMR   (NUM_TMR),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_en     (blk_en),
    .legacy_en  (legacy_en),
    .fire_req   (fire_req),
    .clr_req    (clr_req),
    .tmr_en     (tmr_en),
    .level_trig (level_trig),
    .msg_en     (msg_en),
    .status     (status),
    .irq_lines  (irq_lines),
    .gnt        (msg_gnt)
);

// File: tb/sim_tmr_irq_router.sv
module sim_tmr_irq_router;
    localparam int NT = 4;
    localparam int NL = 32;
    localparam int RW = $clog2(NL);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            blk_en, legacy_en, rtc_irq_in;
    logic [NT-1:0]   fire_req, clr_req, tmr_en, level_trig, msg_en;
    logic [NT*RW-1:0] route_sel;
    logic [NT*64-1:0] msg_route;
    logic [NL-1:0]   irq_lines;
    logic [NT-1:0]   status;
    logic            msg_valid;
    logic [31:0]     msg_addr, msg_data;
    logic [NT*NL-1:0] route_cap;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tmr_irq_router #(.NUM_TMR(NT), .NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .legacy_en(legacy_en),
        .rtc_irq_in(rtc_irq_in), .fire_req(fire_req), .clr_req(clr_req),
        .tmr_en(tmr_en), .level_trig(level_trig), .msg_en(msg_en),
        .route_sel(route_sel), .msg_route(msg_route), .irq_lines(irq_lines),
        .status(status), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data), .route_cap(route_cap)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_fire(input logic [NT-1:0] m);
        fire_req = m; tick(); fire_req = '0;
    endtask

    task automatic pulse_clr(input logic [NT-1:0] m);
        clr_req = m; tick(); clr_req = '0;
    endtask

    task automatic t_reset();
        chk("R1 lines", 64'(irq_lines), 0);
        chk("R1 status", 64'(status), 0);
        chk("R1 msg_valid", 64'(msg_valid), 0);
        for (int i = 0; i < NT; i++)
            chk("R10 cap bit2", 64'(route_cap[i*NL + 2]), 1);
    endtask

    task automatic t_level();
        level_trig = 4'b0100;
        pulse_fire(4'b0100);
        chk("R2 status", 64'(status), 64'h4);
        chk("R2 line", 64'(irq_lines), 64'(32'h1 << 10));
        tick(); tick();
        chk("R2 held", 64'(irq_lines), 64'(32'h1 << 10));
        pulse_clr(4'b0100);
        chk("R4 clr status", 64'(status), 0);
        chk("R4 clr line", 64'(irq_lines), 0);
    endtask

    task automatic t_edge();
        level_trig = '0;
        pulse_fire(4'b0001);
        chk("R3 pulse high", 64'(irq_lines), 64'(32'h1 << 3));
        chk("R3 status clear", 64'(status), 0);
        tick();
        chk("R3 pulse one clock", 64'(irq_lines), 0);
    endtask

    task automatic t_clear_race();
        level_trig = 4'b0100;
        fire_req = 4'b0100; clr_req = 4'b0100; tick();
        fire_req = '0; clr_req = '0;
        chk("R4 clear beats fire", 64'(status), 0);
        chk("R4 clear beats fire line", 64'(irq_lines), 0);
        pulse_fire(4'b0100);
        tmr_en[2] = 1'b0; tick();
        chk("R4 timer disable", 64'(status), 0);
        tmr_en[2] = 1'b1;
        pulse_fire(4'b0100);
        blk_en = 1'b0; tick();
        chk("R4 block disable", 64'(status), 0);
        chk("R4 block disable line", 64'(irq_lines), 0);
        blk_en = 1'b1;
    endtask

    task automatic t_disabled();
        level_trig = 4'b0100;
        blk_en = 1'b0;
        pulse_fire(4'b0100);
        chk("R12 block off fire", 64'(status), 0);
        chk("R12 block off line", 64'(irq_lines), 0);
        blk_en = 1'b1; tmr_en[2] = 1'b0;
        pulse_fire(4'b0100);
        chk("R12 timer off fire", 64'(status), 0);
        tmr_en[2] = 1'b1; tick();
    endtask

    task automatic t_or();
        level_trig = 4'b1100;
        pulse_fire(4'b1100);
        chk("R11 both set", 64'(status), 64'hC);
        pulse_clr(4'b0100);
        chk("R11 line kept", 64'(irq_lines), 64'(32'h1 << 10));
        pulse_clr(4'b1000);
        chk("R11 line dropped", 64'(irq_lines), 0);
    endtask

    task automatic t_legacy();
        legacy_en = 1'b1; level_trig = 4'b0111;
        pulse_fire(4'b0111);
        chk("R5 legacy lines", 64'(irq_lines), 64'(32'h0000_0501));
        pulse_clr(4'b0111);
        chk("R5 legacy cleared", 64'(irq_lines), 0);
        legacy_en = 1'b0; level_trig = '0;
    endtask

    task automatic t_rtc();
        rtc_irq_in = 1'b1; tick();
        chk("R9 rtc pass", 64'(irq_lines), 64'(32'h1 << 8));
        legacy_en = 1'b1; tick();
        chk("R9 rtc gated", 64'(irq_lines), 0);
        legacy_en = 1'b0; tick();
        chk("R9 rtc restored", 64'(irq_lines), 64'(32'h1 << 8));
        rtc_irq_in = 1'b0; tick();
    endtask

    task automatic t_msg();
        msg_en = 4'b1001; tick();
        pulse_fire(4'b1001);
        chk("R6 no write yet", 64'(msg_valid), 0);
        chk("R6 no line", 64'(irq_lines), 0);
        tick();
        chk("R6 valid", 64'(msg_valid), 1);
        chk("R6 addr", 64'(msg_addr), 64'h0000_1000);
        chk("R6 data", 64'(msg_data), 64'hDEAD_BEEF);
        chk("R6 status", 64'(status), 0);
        tick();
        chk("R7 second valid", 64'(msg_valid), 1);
        chk("R7 second addr", 64'(msg_addr), 64'h0000_3000);
        chk("R7 second data", 64'(msg_data), 64'h1234_5678);
        tick();
        chk("R7 idle", 64'(msg_valid), 0);
        msg_en = '0;
    endtask

    task automatic t_msg_rise();
        level_trig = 4'b0100;
        pulse_fire(4'b0100);
        chk("R8 pre hold", 64'(status), 64'h4);
        msg_en[2] = 1'b1; tick();
        chk("R8 status dropped", 64'(status), 0);
        chk("R8 line dropped", 64'(irq_lines), 0);
        msg_en[2] = 1'b0; level_trig = '0; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; blk_en = 1'b1; legacy_en = 1'b0; rtc_irq_in = 1'b0;
        fire_req = '0; clr_req = '0; tmr_en = '1; level_trig = '0; msg_en = '0;
        route_sel = '0;
        route_sel[0*RW +: RW] = RW'(3);
        route_sel[1*RW +: RW] = RW'(5);
        route_sel[2*RW +: RW] = RW'(10);
        route_sel[3*RW +: RW] = RW'(10);
        msg_route = '0;
        msg_route[0*64 +: 64] = 64'h0000_1000_DEAD_BEEF;
        msg_route[3*64 +: 64] = 64'h0000_3000_1234_5678;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1; tick();
        t_level();
        t_edge();
        t_clear_race();
        t_disabled();
        t_or();
        t_legacy();
        t_rtc();
        t_msg();
        t_msg_rise();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule